// File: doc/BRIEF.md
# Low-speed oscillator failure monitor

This block supervises a slow external crystal clock (nominally 32 kHz). It uses a free-running internal low-speed clock as its time base. Once armed, it counts reference-clock cycles since the last toggle of the external clock. It declares the external oscillator dead when that count reaches a programmable limit. The external clock first crosses into the reference domain through a two-flop synchronizer. A failure does four things: it closes a glitch-free gate so the external clock no longer reaches the real-time-clock path, it pulses a request that turns off the internal oscillator's auto-trim mode, it disarms the monitor, and it signals software.

How software is signalled depends on the power mode. In standby the block raises a one-cycle wakeup request. In any other mode it sets a sticky failure flag. The flag drives an interrupt while the interrupt enable is set, and an explicit clear input resets it. The block changes no configuration: the source select and the oscillator enables are inputs and stay as software left them. The gate stays closed until a backup-domain software reset. Only the power-on reset is wired to `rst_n`, so a system reset does not disturb monitoring.

The monitored clock must be fast enough relative to the limit. A clock that stays more than `LIMIT` reference periods between toggles is reported as failed, even though it is still running.

Top module: `lsclk_fail_mon`

## Requirements
- R1: A one-cycle `arm_req` sets `armed` only if `ext_en`, `ext_rdy`, `int_en` and `int_rdy` are all high and `rtc_sel` is not 2'b00. The `rtc_sel` codes are: 2'b00 no source, 2'b01 external clock, 2'b10 internal clock, 2'b11 divided high-speed clock. Otherwise `armed` stays low.
- R2: Once set, `armed` clears only on `rst_n`, on `bkp_swrst`, or on a detected failure. Dropping `arm_req` or any enable or ready flag leaves it set.
- R3: `rst_n` low clears `armed`, `fail_flag`, `irq`, `wakeup`, `trim_clr` and `rtc_clk`. While `vbat_only` is high, no failure is detected and `armed` holds.
- R4: While armed, a failure is declared when `LIMIT` (default 4) consecutive reference cycles pass with no synchronized toggle of `clk_ext`. A clock whose half period is at most about 2.75 reference periods is never reported. A clock whose half period is over 5 reference periods is reported.
- R5: After a failure, `rtc_clk` stays low from the second falling edge of `clk_ext` onward, even if `clk_ext` runs again with `rtc_sel` still 2'b01. It stays low until `bkp_swrst` or `rst_n`, after which it follows `clk_ext` again. `rtc_clk` is never high while `clk_ext` is low.
- R6: Each failure produces exactly one single-cycle `trim_clr` pulse and clears `armed`.
- R7: A failure with `standby` low sets `fail_flag`. The flag stays set until `irq_clr` or `rst_n`. `irq` is high exactly when `fail_flag` and `irq_en` are both high.
- R8: A failure with `standby` high produces one single-cycle `wakeup` pulse and leaves `fail_flag` low.
- R9: With `rtc_sel` = 2'b01 and no failure, `rtc_clk` follows `clk_ext` once two `clk_ext` falling edges have passed. With any other `rtc_sel` value, `rtc_clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Internal low-speed reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clk_ext | input | 1 | Monitored external low-speed clock |
| bkp_swrst | input | 1 | Backup-domain software reset (reference domain) |
| ext_en | input | 1 | External oscillator enabled |
| ext_rdy | input | 1 | External oscillator ready |
| int_en | input | 1 | Internal low-speed oscillator enabled |
| int_rdy | input | 1 | Internal low-speed oscillator ready |
| rtc_sel | input | 2 | Real-time-clock source select |
| standby | input | 1 | Standby power mode active |
| vbat_only | input | 1 | Battery-only supply mode active |
| arm_req | input | 1 | Software request to arm the monitor |
| irq_en | input | 1 | Failure interrupt enable |
| irq_clr | input | 1 | Failure flag clear |
| armed | output | 1 | Monitor armed |
| fail_flag | output | 1 | Sticky failure flag |
| irq | output | 1 | Failure interrupt |
| wakeup | output | 1 | Standby wakeup pulse |
| trim_clr | output | 1 | Pulse that turns off internal oscillator auto-trim |
| rtc_clk | output | 1 | Gated external clock to the real-time clock |

## Verification
The hardest situation to reach is a clock that is still toggling but too slowly, near the detection limit. The hang-low case is the easier one. The bench generates `clk_ext` from its own variable half period, with a fixed phase offset, so its edges never coincide with reference edges. It then steps that half period across the threshold: 1.75, 2.75 and 5.25 reference periods. The second hard case is confirming that the gate stays shut after a failure. The bench restarts `clk_ext` after the failure and samples `rtc_clk` over many reference cycles. It then issues a backup-domain reset and shows that the gate reopens.

// File: rtl/lsmon_pkg.sv
package lsmon_pkg;
  typedef enum logic [1:0] {
    RTC_NONE  = 2'b00,
    RTC_EXT   = 2'b01,
    RTC_INT   = 2'b10,
    RTC_HSDIV = 2'b11
  } rtc_src_e;
endpackage

// File: rtl/lsmon_edge_det.sv
// Counts reference cycles since the last synchronized toggle of clk_ext.
module lsmon_edge_det #(
  parameter int LIMIT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic clk_ext,
  input  logic active,
  output logic fail_det
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

  logic [SYNC_STAGES:0] sh_q;
  logic [CW-1:0]        cnt_q, cnt_nxt;
  logic                 tog;

  // Top bit is the history copy used for toggle detection.
  assign tog = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];

  always_comb begin
    cnt_nxt = cnt_q;
    if (!active || tog)     cnt_nxt = '0;
    else if (cnt_q != LIM_M1) cnt_nxt = cnt_q + CW'(1);
  end

  assign fail_det = active && !tog && (cnt_q == LIM_M1);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= {sh_q[SYNC_STAGES-1:0], clk_ext};
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/lsmon_clk_gate.sv
// Glitch-free gate: enable is retimed on falling edges of the gated clock.
module lsmon_clk_gate #(
  parameter int STAGES = 2
) (
  input  logic clk_ext,
  input  logic rst_n,
  input  logic gate_on,
  output logic clk_out
);
  logic [STAGES-1:0] en_q;

  always_ff @(negedge clk_ext or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= {en_q[STAGES-2:0], gate_on};
  end

  assign clk_out = clk_ext & en_q[STAGES-1];
endmodule

// File: rtl/lsmon_ctrl.sv
// Arming, failure reaction and notification logic in the reference domain.
module lsmon_ctrl
  import lsmon_pkg::*;
(
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       bkp_swrst,
  input  logic       ext_en,
  input  logic       ext_rdy,
  input  logic       int_en,
  input  logic       int_rdy,
  input  logic [1:0] rtc_sel,
  input  logic       standby,
  input  logic       vbat_only,
  input  logic       arm_req,
  input  logic       irq_clr,
  input  logic       fail_det,
  output logic       armed,
  output logic       active,
  output logic       fail_flag,
  output logic       wakeup,
  output logic       trim_clr,
  output logic       gate_on
);
  rtc_src_e src;
  logic arm_ok;
  logic armed_q, armed_nxt;
  logic dead_q,  dead_nxt;
  logic flag_q,  flag_nxt;
  logic wake_q,  wake_nxt;
  logic trim_q,  trim_nxt;
  logic gate_q,  gate_nxt;

  assign src = rtc_src_e'(rtc_sel);

  always_comb begin
    arm_ok = arm_req && ext_en && ext_rdy && int_en && int_rdy && (src != RTC_NONE);

    armed_nxt = armed_q;
    if (bkp_swrst || fail_det) armed_nxt = 1'b0;
    else if (arm_ok)           armed_nxt = 1'b1;

    dead_nxt = dead_q;
    if (bkp_swrst)     dead_nxt = 1'b0;
    else if (fail_det) dead_nxt = 1'b1;

    flag_nxt = flag_q;
    if (fail_det && !standby) flag_nxt = 1'b1;
    else if (irq_clr)         flag_nxt = 1'b0;

    wake_nxt = fail_det && standby;
    trim_nxt = fail_det;
    gate_nxt = (src == RTC_EXT) && !dead_nxt;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      dead_q  <= 1'b0;
      flag_q  <= 1'b0;
      wake_q  <= 1'b0;
      trim_q  <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      armed_q <= armed_nxt;
      dead_q  <= dead_nxt;
      flag_q  <= flag_nxt;
      wake_q  <= wake_nxt;
      trim_q  <= trim_nxt;
      gate_q  <= gate_nxt;
    end
  end

  assign armed     = armed_q;
  assign active    = armed_q && !vbat_only;
  assign fail_flag = flag_q;
  assign wakeup    = wake_q;
  assign trim_clr  = trim_q;
  assign gate_on   = gate_q;
endmodule

// File: rtl/lsclk_fail_mon.sv
module lsclk_fail_mon #(
  parameter int LIMIT       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int GATE_STAGES = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       clk_ext,
  input  logic       bkp_swrst,
  input  logic       ext_en,
  input  logic       ext_rdy,
  input  logic       int_en,
  input  logic       int_rdy,
  input  logic [1:0] rtc_sel,
  input  logic       standby,
  input  logic       vbat_only,
  input  logic       arm_req,
  input  logic       irq_en,
  input  logic       irq_clr,
  output logic       armed,
  output logic       fail_flag,
  output logic       irq,
  output logic       wakeup,
  output logic       trim_clr,
  output logic       rtc_clk
);
  logic active, fail_det, gate_on;

  lsmon_edge_det #(.LIMIT(LIMIT), .SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .clk_ext  (clk_ext),
    .active   (active),
    .fail_det (fail_det)
  );

  lsmon_ctrl u_ctrl (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .bkp_swrst (bkp_swrst),
    .ext_en    (ext_en),
    .ext_rdy   (ext_rdy),
    .int_en    (int_en),
    .int_rdy   (int_rdy),
    .rtc_sel   (rtc_sel),
    .standby   (standby),
    .vbat_only (vbat_only),
    .arm_req   (arm_req),
    .irq_clr   (irq_clr),
    .fail_det  (fail_det),
    .armed     (armed),
    .active    (active),
    .fail_flag (fail_flag),
    .wakeup    (wakeup),
    .trim_clr  (trim_clr),
    .gate_on   (gate_on)
  );

  lsmon_clk_gate #(.STAGES(GATE_STAGES)) u_gate (
    .clk_ext (clk_ext),
    .rst_n   (rst_n),
    .gate_on (gate_on),
    .clk_out (rtc_clk)
  );

  assign irq = fail_flag & irq_en;
endmodule

// File: rtl/lsmon_chk.sv
module lsmon_chk (
  input logic       clk_ref,
  input logic       rst_n,
  input logic       clk_ext,
  input logic       bkp_swrst,
  input logic       ext_en,
  input logic       ext_rdy,
  input logic       int_en,
  input logic       int_rdy,
  input logic [1:0] rtc_sel,
  input logic       standby,
  input logic       vbat_only,
  input logic       arm_req,
  input logic       irq_clr,
  input logic       armed,
  input logic       fail_flag,
  input logic       wakeup,
  input logic       trim_clr,
  input logic       rtc_clk
);
  assert_arm_guard_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (armed && !$past(armed)) |->
      $past(arm_req && ext_en && ext_rdy && int_en && int_rdy && (rtc_sel != 2'b00)));

  assert_no_sw_clear_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(armed) |-> ($past(bkp_swrst) || trim_clr));

  assert_vbat_quiet_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $past(vbat_only) |-> !trim_clr);

  assert_gate_low_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    rtc_clk |-> clk_ext);

  assert_trim_single_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    trim_clr |=> !trim_clr);

  assert_flag_sticky_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (fail_flag && !irq_clr) |=> fail_flag);

  assert_flag_on_fail_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (trim_clr && !$past(standby)) |-> fail_flag);

  assert_wake_on_fail_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    wakeup |-> trim_clr);
endmodule

bind lsclk_fail_mon lsmon_chk u_chk (
  .clk_ref   (clk_ref),
  .rst_n     (rst_n),
  .clk_ext   (clk_ext),
  .bkp_swrst (bkp_swrst),
  .ext_en    (ext_en),
  .ext_rdy   (ext_rdy),
  .int_en    (int_en),
  .int_rdy   (int_rdy),
  .rtc_sel   (rtc_sel),
  .standby   (standby),
  .vbat_only (vbat_only),
  .arm_req   (arm_req),
  .irq_clr   (irq_clr),
  .armed     (armed),
  .fail_flag (fail_flag),
  .wakeup    (wakeup),
  .trim_clr  (trim_clr),
  .rtc_clk   (rtc_clk)
);

// File: tb/sim_lsclk_fail_mon.sv
`timescale 1ns/1ps
module sim_lsclk_fail_mon;
  logic clk = 1'b0;
  logic rst_n, clk_ext, bkp_swrst, ext_en, ext_rdy, int_en, int_rdy;
  logic [1:0] rtc_sel;
  logic standby, vbat_only, arm_req, irq_en, irq_clr;
  logic armed, fail_flag, irq, wakeup, trim_clr, rtc_clk;

  int errors = 0;
  int checks = 0;
  int trim_cnt = 0;
  int wake_cnt = 0;
  int ext_half = 35;
  bit ext_run  = 1'b1;

  always #10 clk = ~clk;

  // External clock: phase offset of 3 ns keeps its edges off reference edges.
  // It always completes a high phase, so stopping leaves it low.
  initial begin
    clk_ext = 1'b0;
    #3;
    forever begin
      #(ext_half);
      if (ext_run || clk_ext) clk_ext = ~clk_ext;
    end
  end

  always @(posedge clk) begin
    if (trim_clr) trim_cnt++;
    if (wakeup)   wake_cnt++;
  end

  lsclk_fail_mon u0 (
    .clk_ref(clk), .rst_n(rst_n), .clk_ext(clk_ext), .bkp_swrst(bkp_swrst),
    .ext_en(ext_en), .ext_rdy(ext_rdy), .int_en(int_en), .int_rdy(int_rdy),
    .rtc_sel(rtc_sel), .standby(standby), .vbat_only(vbat_only),
    .arm_req(arm_req), .irq_en(irq_en), .irq_clr(irq_clr),
    .armed(armed), .fail_flag(fail_flag), .irq(irq), .wakeup(wakeup),
    .trim_clr(trim_clr), .rtc_clk(rtc_clk)
  );

  // {ext_en, ext_rdy, int_en, int_rdy, rtc_sel[1:0], expected armed}
  localparam logic [6:0] VEC [8] = '{
    7'b1111_01_1, 7'b1111_10_1, 7'b1111_11_1, 7'b1111_00_0,
    7'b0111_01_0, 7'b1011_01_0, 7'b1101_01_0, 7'b1110_01_0
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bkp_pulse();
    bkp_swrst = 1'b1; cyc(1); bkp_swrst = 1'b0; cyc(1);
  endtask

  task automatic do_arm();
    bkp_pulse();
    ext_en = 1; ext_rdy = 1; int_en = 1; int_rdy = 1; rtc_sel = 2'b01;
    arm_req = 1'b1; cyc(1); arm_req = 1'b0; cyc(1);
  endtask

  task automatic follow(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1);
      chk(tag, int'(rtc_clk), int'(clk_ext));
    end
  endtask

  task automatic held_low(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1);
      chk(tag, int'(rtc_clk), 0);
    end
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t0, w0;
    rst_n = 0; bkp_swrst = 0; ext_en = 0; ext_rdy = 0; int_en = 0; int_rdy = 0;
    rtc_sel = 2'b00; standby = 0; vbat_only = 0; arm_req = 0; irq_en = 0; irq_clr = 0;
    cyc(5);
    chk("R3 reset armed", int'(armed), 0);
    chk("R3 reset flag", int'(fail_flag), 0);
    chk("R3 reset irq", int'(irq), 0);
    chk("R3 reset wakeup", int'(wakeup), 0);
    chk("R3 reset trim", int'(trim_clr), 0);
    chk("R3 reset rtc_clk", int'(rtc_clk), 0);
    rst_n = 1;
    cyc(10);

    // R1: arm acceptance table
    foreach (VEC[k]) begin
      bkp_pulse();
      {ext_en, ext_rdy, int_en, int_rdy, rtc_sel} = VEC[k][6:1];
      arm_req = 1'b1; cyc(1); arm_req = 1'b0; cyc(1);
      chk($sformatf("R1 vector %0d", k), int'(armed), int'(VEC[k][0]));
    end

    // R2: software cannot disarm
    do_arm();
    ext_en = 0; int_rdy = 0;
    cyc(10);
    chk("R2 armed holds", int'(armed), 1);
    ext_en = 1; int_rdy = 1;
    bkp_pulse();
    chk("R2 backup reset disarms", int'(armed), 0);

    // R9 / R4: healthy fast clock passes through, no failure
    do_arm();
    cyc(20);
    follow("R9 rtc_clk follows", 16);
    chk("R4 fast clock no fail", int'(armed), 1);
    ext_half = 55;
    cyc(60);
    chk("R4 near-limit clock no fail", int'(armed), 1);
    chk("R4 near-limit flag", int'(fail_flag), 0);
    ext_half = 35;
    cyc(10);

    // R6 / R7: stopped clock, normal mode
    irq_en = 1; t0 = trim_cnt; w0 = wake_cnt;
    ext_run = 0;
    cyc(20);
    chk("R6 disarmed on fail", int'(armed), 0);
    chk("R6 one trim pulse", trim_cnt - t0, 1);
    chk("R7 flag set", int'(fail_flag), 1);
    chk("R7 irq set", int'(irq), 1);
    chk("R8 no wakeup outside standby", wake_cnt - w0, 0);

    // R5: gate stays shut after restart
    ext_run = 1;
    repeat (3) @(negedge clk_ext);
    held_low("R5 gate closed", 20);

    // R7: sticky flag and mask
    irq_en = 0; cyc(1);
    chk("R7 irq masked", int'(irq), 0);
    cyc(10);
    chk("R7 flag sticky", int'(fail_flag), 1);
    irq_clr = 1; cyc(1); irq_clr = 0; cyc(1);
    chk("R7 flag cleared", int'(fail_flag), 0);

    // R5: backup reset reopens the gate
    bkp_pulse();
    cyc(20);
    follow("R5 gate reopened", 8);

    // R8: standby failure
    do_arm();
    standby = 1; t0 = trim_cnt; w0 = wake_cnt;
    ext_run = 0;
    cyc(20);
    chk("R8 one wakeup", wake_cnt - w0, 1);
    chk("R8 flag stays low", int'(fail_flag), 0);
    chk("R6 trim in standby", trim_cnt - t0, 1);
    standby = 0; ext_run = 1;
    cyc(10);

    // R3: battery-only suspends detection, power-on reset clears
    do_arm();
    vbat_only = 1; t0 = trim_cnt;
    ext_run = 0;
    cyc(20);
    chk("R3 vbat armed holds", int'(armed), 1);
    chk("R3 vbat no fail", int'(fail_flag), 0);
    chk("R3 vbat no trim", trim_cnt - t0, 0);
    rst_n = 0; cyc(2);
    chk("R3 reset disarms", int'(armed), 0);
    rst_n = 1; vbat_only = 0; ext_run = 1;
    cyc(10);

    // R4: slow clock reported as failed
    do_arm();
    t0 = trim_cnt;
    ext_half = 105;
    cyc(40);
    chk("R4 slow clock disarms", int'(armed), 0);
    chk("R4 slow clock trim", trim_cnt - t0, 1);
    ext_half = 35;

    // R9: other source selected keeps rtc_clk low
    bkp_pulse();
    rtc_sel = 2'b10;
    cyc(20);
    held_low("R9 non-ext source", 8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule